// File: doc/BRIEF.md
# Slave Audio Serial Transmitter with Startup Muting

This block sends a left/right pair of 16-bit two's-complement samples, most significant bit first, on one serial data line. It is a slave on a three-wire audio link. The bit clock and the frame (word-select) clock come from outside the block. All sequential logic runs on the bit clock. The frame clock is captured on bit-clock rising edges, and the data line changes on falling edges. A mode pin selects one of two framings:
- Left-justified framing: the frame clock is high for the left word, and the MSB leaves on the same falling edge that moves the frame clock.
- I2S framing: the frame clock is low for the left word, and the MSB follows one bit clock after the frame-clock edge.

The active-low power-down input resets the block and holds the output at zero. A two-state sequencer counts frame-clock rising edges after release. In state MUTE, every word loaded is zero. The transition MUTE→LIVE is taken on the `MUTE_FRAMES`-th rising edge (default 4128). The word whose slot starts on that edge is still zero, and every later word carries data. LIVE holds until power-down is asserted, which returns the sequencer to MUTE with the count cleared. The left/right pair is captured at the start of each left slot, so both words of a frame come from the same sample period. Bit clocks of 32 and 64 per frame are both supported. Bit periods after the 16th in a slot are driven low.

Top module: `aud_slave_tx`

## Requirements
- R1: With `fmt_i2s` = 0, the left word is sent while `lrck` is 1 and the right word while `lrck` is 0. The MSB appears in the first bit period after each `lrck` transition.
- R2: With `fmt_i2s` = 1, the left word is sent while `lrck` is 0 and the right word while `lrck` is 1. The MSB appears in the second bit period after each `lrck` transition.
- R3: Each word is 16 bits of two's complement sent MSB first, one bit per bit period, and reproduces the input word exactly.
- R4: With 32 bit periods per slot, every bit period after the 16 data bits of a slot is 0.
- R5: With 16 bit periods per slot, consecutive words follow each other with no gap or padding.
- R6: While `pdn_n` = 0, `sdto` is 0, whatever the frame clock and sample inputs do.
- R7: After `pdn_n` rises, each word whose slot starts before more than `MUTE_FRAMES` `lrck` rising edges have been counted is sent as 0. The slot starting on the `MUTE_FRAMES`-th rising edge is still 0. Later slots carry data.
- R8: Both words of a frame come from `left_in`/`right_in` as they stood at the start of the left slot. A change during the left slot appears only from the next frame onwards.
- R9: Asserting `pdn_n` = 0 after data has started clears the count, so the full muting interval repeats after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the link master; all state is clocked by it |
| lrck | input | 1 | Frame clock from the link master; its level selects the channel |
| fmt_i2s | input | 1 | Framing select: 0 = left-justified, 1 = I2S |
| pdn_n | input | 1 | Active-low power-down and asynchronous reset |
| left_in | input | 16 | Left sample, two's complement |
| right_in | input | 16 | Right sample, two's complement |
| sdto | output | 1 | Serial data output |

## Verification
The end of muting and a word load fall on the same bit-clock falling edge. The edge that counts the last frame-clock rise also loads the slot that this rise opens. That slot must stay zero, and the next slot must carry data. The stimulus table provokes this in both framings and at both slot lengths. The bench keeps its own count of rising edges and judges every word and every padding bit on its own. The left-slot capture meets a sample change in the same frame. The bench judges this by changing the inputs in the middle of a left slot and expecting the old right word.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic {
        ST_MUTE = 1'b0,
        ST_LIVE = 1'b1
    } mute_state_e;

    localparam int DEF_WORD_W      = 16;
    localparam int DEF_MUTE_FRAMES = 4128;

endpackage

// File: rtl/aud_tx_lr_track.sv
module aud_tx_lr_track (
    input  logic bclk,
    input  logic rst_n,
    input  logic lrck,
    output logic lr_smp,
    output logic lr_prev,
    output logic primed,
    output logic slot_start,
    output logic rise
);

    logic smp_ok;

    // frame clock captured where it is stable: bit-clock rising edge
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            lr_smp <= 1'b0;
            smp_ok <= 1'b0;
        end else begin
            lr_smp <= lrck;
            smp_ok <= 1'b1;
        end
    end

    // previous level held on the falling edge, where words are loaded
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            primed  <= 1'b0;
        end else begin
            lr_prev <= lr_smp;
            primed  <= smp_ok;
        end
    end

    assign slot_start = primed & (lr_smp ^ lr_prev);
    assign rise       = slot_start & lr_smp;

endmodule

// File: rtl/aud_tx_mute_seq.sv
module aud_tx_mute_seq
    import aud_tx_pkg::*;
#(
    parameter int MUTE_FRAMES = DEF_MUTE_FRAMES,
    parameter int CNT_W       = $clog2(MUTE_FRAMES + 1)
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             rise,
    output logic             live,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(MUTE_FRAMES - 1);

    mute_state_e state_q, state_d;

    // state register
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_MUTE;
        end else begin
            state_q <= state_d;
        end
    end

    // rising-edge count, frozen once data flows
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state_q == ST_MUTE && rise) begin
            cnt <= cnt + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MUTE: if (rise && cnt == LAST) state_d = ST_LIVE;
            ST_LIVE: state_d = ST_LIVE;
            default: state_d = ST_MUTE;
        endcase
    end

    // outputs
    always_comb begin
        live = (state_q == ST_LIVE);
    end

endmodule

// File: rtl/aud_tx_shifter.sv
module aud_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              fmt_i2s,
    input  logic              lrck,
    input  logic              lr_smp,
    input  logic              lr_prev,
    input  logic              primed,
    input  logic              slot_start,
    input  logic              live,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              sdto
);

    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] right_hold;
    logic [WORD_W-1:0] pick;
    logic [WORD_W-1:0] load_val;
    logic              left_slot;
    logic              early;
    logic              early_bit;

    // left slot: frame clock high in justified mode, low in I2S mode
    assign left_slot = lr_smp ^ fmt_i2s;

    always_comb begin
        pick     = left_slot ? left_in : right_hold;
        load_val = live ? pick : '0;
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            right_hold <= '0;
        end else if (slot_start) begin
            if (left_slot) right_hold <= right_in;
            // justified mode already sent the MSB on the previous edge
            shreg <= fmt_i2s ? load_val : {load_val[WORD_W-2:0], 1'b0};
        end else begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    // justified mode: MSB follows the frame-clock change before the load edge
    assign early     = ~fmt_i2s & primed & (lrck ^ lr_prev);
    assign early_bit = live & (lrck ? left_in[WORD_W-1] : right_hold[WORD_W-1]);
    assign sdto      = early ? early_bit : shreg[WORD_W-1];

endmodule

// File: rtl/aud_slave_tx.sv
module aud_slave_tx
    import aud_tx_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int MUTE_FRAMES = DEF_MUTE_FRAMES
) (
    input  logic              bclk,
    input  logic              lrck,
    input  logic              fmt_i2s,
    input  logic              pdn_n,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              sdto
);

    localparam int CNT_W = $clog2(MUTE_FRAMES + 1);

    logic             lr_smp;
    logic             lr_prev;
    logic             primed;
    logic             slot_start;
    logic             rise;
    logic             live;
    logic [CNT_W-1:0] mute_cnt;

    aud_tx_lr_track u_track (
        .bclk       (bclk),
        .rst_n      (pdn_n),
        .lrck       (lrck),
        .lr_smp     (lr_smp),
        .lr_prev    (lr_prev),
        .primed     (primed),
        .slot_start (slot_start),
        .rise       (rise)
    );

    aud_tx_mute_seq #(
        .MUTE_FRAMES (MUTE_FRAMES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .bclk  (bclk),
        .rst_n (pdn_n),
        .rise  (rise),
        .live  (live),
        .cnt   (mute_cnt)
    );

    aud_tx_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .bclk       (bclk),
        .rst_n      (pdn_n),
        .fmt_i2s    (fmt_i2s),
        .lrck       (lrck),
        .lr_smp     (lr_smp),
        .lr_prev    (lr_prev),
        .primed     (primed),
        .slot_start (slot_start),
        .live       (live),
        .left_in    (left_in),
        .right_in   (right_in),
        .sdto       (sdto)
    );

endmodule

// File: rtl/aud_slave_tx_chk.sv
module aud_slave_tx_chk #(
    parameter int MUTE_FRAMES = 4128,
    parameter int CNT_W       = 13
) (
    input logic             bclk,
    input logic             pdn_n,
    input logic             sdto,
    input logic             live,
    input logic [CNT_W-1:0] mute_cnt
);

    always @(posedge bclk) begin
        if (!pdn_n) begin
            assert_pd_zero_R6: assert (sdto == 1'b0)
                else $error("sdto high during power-down");
        end
    end

    assert_mute_silent_R7: assert property (@(posedge bclk) disable iff (!pdn_n)
        !live |-> !sdto)
        else $error("data left the block while muted");

    assert_live_sticky_R7: assert property (@(negedge bclk) disable iff (!pdn_n)
        live |=> live)
        else $error("left the live state without power-down");

    assert_live_count_R7: assert property (@(posedge bclk) disable iff (!pdn_n)
        live |-> (mute_cnt == CNT_W'(MUTE_FRAMES)))
        else $error("live before the full count");

    assert_mute_count_R7: assert property (@(posedge bclk) disable iff (!pdn_n)
        !live |-> (mute_cnt < CNT_W'(MUTE_FRAMES)))
        else $error("count complete but still muted");

endmodule

bind aud_slave_tx aud_slave_tx_chk #(
    .MUTE_FRAMES (MUTE_FRAMES),
    .CNT_W       (CNT_W)
) u_chk (
    .bclk     (bclk),
    .pdn_n    (pdn_n),
    .sdto     (sdto),
    .live     (live),
    .mute_cnt (mute_cnt)
);

// File: tb/tb_aud_slave_tx.sv
module tb_aud_slave_tx;

    localparam int CLK_PERIOD = 20;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int NM         = 8;
    localparam int NV         = 6;
    // {fmt_i2s, 32-bit slot, left, right}
    localparam logic [33:0] VEC [0:NV-1] = '{
        {1'b0, 1'b0, 16'h8001, 16'h7FFE},
        {1'b1, 1'b0, 16'hA5C3, 16'h5A3C},
        {1'b0, 1'b1, 16'h1234, 16'hFEDC},
        {1'b1, 1'b1, 16'hFFFF, 16'h0000},
        {1'b1, 1'b0, 16'h0001, 16'h8000},
        {1'b0, 1'b1, 16'h7FFF, 16'h8000}
    };

    logic        bclk, lrck, fmt_i2s, pdn_n, sdto;
    logic [15:0] left_in, right_in;

    aud_slave_tx #(.WORD_W(16), .MUTE_FRAMES(NM)) dut (
        .bclk(bclk), .lrck(lrck), .fmt_i2s(fmt_i2s), .pdn_n(pdn_n),
        .left_in(left_in), .right_in(right_in), .sdto(sdto)
    );

    logic        cap [0:1023];
    int          ncap, nfr, slot_len, rise_cnt, n_chk, n_fail;
    int          fstart [0:31];
    logic [15:0] exL [0:31];
    logic [15:0] exR [0:31];
    bit          liveL [0:31];
    bit          liveR [0:31];
    bit          swp [0:31];
    bit          pd_hold, done;
    string       run_tag;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic lr);
        bclk = 1'b0;
        #1 lrck = lr;
        #(HALF-1) bclk = 1'b1;
        #1 cap[ncap] = sdto;
        if (ncap < 1023) ncap++;
        #(HALF-1);
    endtask

    task automatic slot(input logic lvl, input bit sw, input logic [15:0] l2, input logic [15:0] r2);
        for (int p = 0; p < slot_len; p++) begin
            if (sw && p == 8) begin
                left_in  = l2;
                right_in = r2;
            end
            tick(lvl);
        end
    endtask

    task automatic frame(input logic [15:0] l, input logic [15:0] r, input bit sw,
                         input logic [15:0] l2, input logic [15:0] r2);
        logic lvl_l;
        lvl_l    = ~fmt_i2s;
        left_in  = l;
        right_in = r;
        fstart[nfr] = ncap;
        exL[nfr] = l;
        exR[nfr] = r;
        swp[nfr] = sw;
        liveL[nfr] = !pd_hold && rise_cnt >= NM;
        if (!pd_hold && lvl_l) rise_cnt++;
        slot(lvl_l, sw, l2, r2);
        liveR[nfr] = !pd_hold && rise_cnt >= NM;
        if (!pd_hold && !lvl_l) rise_cnt++;
        slot(~lvl_l, 1'b0, 16'h0, 16'h0);
        nfr++;
    endtask

    task automatic begin_run(input logic fmt, input logic wide, input bit pdlow, input string tag);
        fmt_i2s  = fmt;
        slot_len = wide ? 32 : 16;
        pd_hold  = pdlow;
        run_tag  = tag;
        pdn_n    = 1'b0;
        left_in  = 16'h0;
        right_in = 16'h0;
        ncap     = 0;
        for (int i = 0; i < 3; i++) tick(fmt);
        chk("R6 reset state", {15'h0, cap[ncap-1]}, 16'h0);
        if (!pdlow) pdn_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(fmt);
        ncap     = 0;
        nfr      = 0;
        rise_cnt = 0;
    endtask

    task automatic finish_run();
        int          off, base;
        logic [15:0] got, pad;
        string       tg, t2;
        frame(16'h0, 16'h0, 1'b0, 16'h0, 16'h0);
        off = fmt_i2s ? 1 : 0;
        tg  = fmt_i2s ? "R2,R3" : "R1,R3";
        tg  = (slot_len == 16) ? {tg, ",R5"} : {tg, ",R4"};
        if (pd_hold) tg = "R6";
        tg  = {tg, run_tag};
        for (int f = 0; f < nfr - 1; f++) begin
            for (int s = 0; s < 2; s++) begin
                base = fstart[f] + s * slot_len + off;
                for (int i = 0; i < 16; i++) got[15-i] = cap[base+i];
                t2 = (s == 0 ? liveL[f] : liveR[f]) ? tg : {tg, ",R7"};
                if (swp[f]) t2 = {t2, ",R8"};
                chk($sformatf("%s frame %0d slot %0d", t2, f, s), got,
                    (s == 0) ? (liveL[f] ? exL[f] : 16'h0) : (liveR[f] ? exR[f] : 16'h0));
                if (slot_len > 16) begin
                    pad = 16'h0;
                    for (int i = 16; i < slot_len; i++) pad[i-16] = cap[base+i];
                    chk($sformatf("R4 padding frame %0d slot %0d", f, s), pad, 16'h0);
                end
            end
        end
    endtask

    initial begin
        bclk = 1'b1; lrck = 1'b0; fmt_i2s = 1'b0; pdn_n = 1'b0;
        left_in = 16'h0; right_in = 16'h0;
        n_chk = 0; n_fail = 0; done = 1'b0;
        #5;
        // table walk: each vector restarts from power-down (R7 and R9 boundary)
        for (int v = 0; v < NV; v++) begin
            begin_run(VEC[v][33], VEC[v][32], 1'b0, (v > 0) ? ",R9" : "");
            for (int k = 0; k < NM + 2; k++)
                frame(VEC[v][31:16], VEC[v][15:0], 1'b0, 16'h0, 16'h0);
            finish_run();
        end
        // R6: power-down held while data and clocks run
        begin_run(1'b0, 1'b0, 1'b1, "");
        for (int k = 0; k < 3; k++) frame(16'hFFFF, 16'hFFFF, 1'b0, 16'h0, 16'h0);
        finish_run();
        // R8: inputs change in mid left slot, in both framings
        for (int f = 0; f < 2; f++) begin
            begin_run(f[0], 1'b0, 1'b0, "");
            for (int k = 0; k < NM + 1; k++) frame(16'h1357, 16'h2468, 1'b0, 16'h0, 16'h0);
            frame(16'h1357, 16'h2468, 1'b1, 16'hC0DE, 16'hBEEF);
            frame(16'hC0DE, 16'hBEEF, 1'b0, 16'h0, 16'h0);
            finish_run();
        end
        // R9: second power-down after live data repeats the muting
        begin_run(1'b1, 1'b1, 1'b0, "");
        for (int k = 0; k < NM + 2; k++) frame(16'h4321, 16'h8765, 1'b0, 16'h0, 16'h0);
        finish_run();
        begin_run(1'b1, 1'b1, 1'b0, ",R9");
        for (int k = 0; k < NM + 2; k++) frame(16'h4321, 16'h8765, 1'b0, 16'h0, 16'h0);
        finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule